// File: doc/BRIEF.md
# Standby Mode Control Register

This block is a single 8-bit control register with a small mode sequencer. Together they move a microcontroller core from normal running into one of two low-power states. The CPU writes trigger bits to request sleep or stop. A request is accepted only while the core is running and no interrupt request is pending. The sequencer then turns off the CPU clock alone (sleep) or both the CPU and peripheral clocks (stop). It holds that state until an interrupt request or a wake event brings the core back to running on the next clock edge.

The same register holds a persistent pin-state select. When the select is set, every external pin is released to high impedance while the device is stopped. Pins whose pull-up is enabled are then pulled up rather than left floating. The register also has a write-only software reset trigger that produces a one-cycle pulse, and a write-only timer-mode select that drives a level output. Only the pin-state select can be read back.

Power mode encoding on `pwr_mode`: 2'b00 running, 2'b01 sleep, 2'b10 stop.

Top module: `stby_ctrl_top`

## Requirements
- R1: After reset, `pwr_mode` is 2'b00, both clock enables are 1, `rdata` is 8'h00, `swrst_pulse` and `tmr_sel` are 0, and no pin is high impedance or pulled up.
- R2: `rdata` always equals {2'b00, pinsel, 5'b00000}, where pinsel is the last value written to bit 5. Bits 7, 6, 4, 3 and 2..0 always read 0.
- R3: Writing 1 to bit 7 (stop request) while running with no interrupt pending gives `pwr_mode` = 2'b10 after that clock edge, with `cpu_clk_en` = 0 and `per_clk_en` = 0. A write with bit 7 and bit 6 both 0 leaves the mode unchanged.
- R4: Writing 1 to bit 6 (sleep request) with bit 7 = 0, while running with no interrupt pending, gives `pwr_mode` = 2'b01 after that edge, with `cpu_clk_en` = 0 and `per_clk_en` = 1.
- R5: When bits 7 and 6 are written as 1 together, stop is entered.
- R6: If `irq_pending` is 1 during a write of either request bit, the write is ignored and `pwr_mode` stays 2'b00.
- R7: In sleep or stop, a cycle with `irq_pending` or `wake_evt` high returns `pwr_mode` to 2'b00 on the next edge, with both clock enables back at 1 and all pins released.
- R8: `pin_hiz` is all ones only when `pwr_mode` is 2'b10 and pinsel is 1, and all zeros otherwise. `pin_pullup` equals `pin_hiz` AND `pullup_en`, bit by bit.
- R9: A write with bit 4 = 1 gives `swrst_pulse` = 1 for the one cycle after that write's edge. Otherwise `swrst_pulse` is 0.
- R10: `tmr_sel` takes the value of bit 3 from every write.
- R11: In sleep or stop with neither `irq_pending` nor `wake_evt` high, the mode holds, and request bits written in that state do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| irq_pending | input | 1 | Some interrupt request is asserted |
| wake_evt | input | 1 | External wake event |
| pullup_en | input | NPIN | Per-pin pull-up selection |
| pwr_mode | output | 2 | Current power mode (00 run, 01 sleep, 10 stop) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pin_hiz | output | NPIN | Per-pin high-impedance enable |
| pin_pullup | output | NPIN | Per-pin pull-up override |
| swrst_pulse | output | 1 | One-cycle software reset pulse |
| tmr_sel | output | 1 | Timer-mode select level |

## Verification
The bench builds the block with NPIN = 4, so every 4-bit pull-up pattern is applied. It sweeps all 256 write values, each once with an interrupt pending and once without. Every combination of the request, reset, timer and pin-select bits is therefore checked against the mode, clock, pin and readback outputs. Each entered low-power state is left in turn by an interrupt and by a wake event. Where bit 2 of the sweep value is set, a request is also written while the core is already in a low-power state, to show that the mode holds.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_SLEEP = 2'b01,
        PM_STOP  = 2'b10
    } pwr_mode_e;

    localparam int REG_W     = 8;
    localparam int BIT_STOP  = 7;
    localparam int BIT_SLEEP = 6;
    localparam int BIT_PINS  = 5;
    localparam int BIT_SWRST = 4;
    localparam int BIT_TMR   = 3;

    typedef struct packed {
        logic pinsel;
        logic tmr;
        logic swrst;
    } ctl_reg_t;

    typedef struct packed {
        pwr_mode_e mode;
        logic      cpu_en;
        logic      per_en;
    } seq_state_t;

endpackage

// File: rtl/stby_ctl_reg.sv
module stby_ctl_reg
    import stby_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             stop_req,
    output logic             sleep_req,
    output logic             pinsel,
    output logic             tmr_sel,
    output logic             swrst_pulse
);

    ctl_reg_t reg_d, reg_q;
    logic     unused_low_bits;

    assign unused_low_bits = ^wdata[2:0];

    always_comb begin
        reg_d       = reg_q;
        reg_d.swrst = 1'b0;
        if (wr_en) begin
            reg_d.pinsel = wdata[BIT_PINS];
            reg_d.tmr    = wdata[BIT_TMR];
            reg_d.swrst  = wdata[BIT_SWRST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    always_comb begin
        rdata           = '0;
        rdata[BIT_PINS] = reg_q.pinsel;
    end

    assign stop_req    = wr_en & wdata[BIT_STOP];
    assign sleep_req   = wr_en & wdata[BIT_SLEEP];
    assign pinsel      = reg_q.pinsel;
    assign tmr_sel     = reg_q.tmr;
    assign swrst_pulse = reg_q.swrst;

    AST_SWRST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_pulse |-> $past(wr_en && wdata[BIT_SWRST])); // R9
    AST_TMR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tmr_sel == $past(wdata[BIT_TMR]))); // R10

endmodule

// File: rtl/stby_mode_seq.sv
module stby_mode_seq
    import stby_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_req,
    input  logic      sleep_req,
    input  logic      irq_pending,
    input  logic      wake_evt,
    output pwr_mode_e mode,
    output logic      cpu_clk_en,
    output logic      per_clk_en
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            PM_RUN: begin
                if (!irq_pending) begin
                    if (stop_req)       st_d.mode = PM_STOP;
                    else if (sleep_req) st_d.mode = PM_SLEEP;
                end
            end
            PM_SLEEP, PM_STOP: begin
                if (irq_pending || wake_evt) st_d.mode = PM_RUN;
            end
            default: st_d.mode = PM_RUN;
        endcase
        st_d.cpu_en = (st_d.mode == PM_RUN);
        st_d.per_en = (st_d.mode != PM_STOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= PM_RUN;
            st_q.cpu_en <= 1'b1;
            st_q.per_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode       = st_q.mode;
    assign cpu_clk_en = st_q.cpu_en;
    assign per_clk_en = st_q.per_en;

    AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_RUN && (stop_req || sleep_req) && irq_pending) |=> mode == PM_RUN); // R6
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_RUN && stop_req && !irq_pending) |=> mode == PM_STOP); // R5
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_RUN && sleep_req && !stop_req && !irq_pending) |=> mode == PM_SLEEP); // R4
    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PM_RUN && (irq_pending || wake_evt)) |=> mode == PM_RUN); // R7
    AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PM_RUN && !irq_pending && !wake_evt) |=> $stable(mode)); // R11
    AST_STOP_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_STOP) |-> (!cpu_clk_en && !per_clk_en)); // R3
    AST_SLEEP_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_SLEEP) |-> (!cpu_clk_en && per_clk_en)); // R4

endmodule

// File: rtl/stby_pin_ctl.sv
module stby_pin_ctl
    import stby_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pwr_mode_e       mode,
    input  logic            pinsel,
    input  logic [NPIN-1:0] pullup_en,
    output logic [NPIN-1:0] pin_hiz,
    output logic [NPIN-1:0] pin_pullup
);

    logic release_pins;

    assign release_pins = (mode == PM_STOP) && pinsel;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        assign pin_hiz[p]    = release_pins;
        assign pin_pullup[p] = release_pins & pullup_en[p];
    end

    AST_HIZ_ONLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (|pin_hiz) |-> (mode == PM_STOP && pinsel)); // R8
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_STOP && pinsel) |-> (&pin_hiz)); // R8

endmodule

// File: rtl/stby_ctrl_top.sv
module stby_ctrl_top
    import stby_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic            irq_pending,
    input  logic            wake_evt,
    input  logic [NPIN-1:0] pullup_en,
    output logic [1:0]      pwr_mode,
    output logic            cpu_clk_en,
    output logic            per_clk_en,
    output logic [NPIN-1:0] pin_hiz,
    output logic [NPIN-1:0] pin_pullup,
    output logic            swrst_pulse,
    output logic            tmr_sel
);

    logic      stop_req, sleep_req, pinsel;
    pwr_mode_e mode;

    stby_ctl_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wdata       (wdata),
        .rdata       (rdata),
        .stop_req    (stop_req),
        .sleep_req   (sleep_req),
        .pinsel      (pinsel),
        .tmr_sel     (tmr_sel),
        .swrst_pulse (swrst_pulse)
    );

    stby_mode_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .sleep_req   (sleep_req),
        .irq_pending (irq_pending),
        .wake_evt    (wake_evt),
        .mode        (mode),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en)
    );

    stby_pin_ctl #(.NPIN(NPIN)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .pinsel     (pinsel),
        .pullup_en  (pullup_en),
        .pin_hiz    (pin_hiz),
        .pin_pullup (pin_pullup)
    );

    assign pwr_mode = mode;

endmodule

// File: tb/sim_stby_ctrl_top.sv
module sim_stby_ctrl_top;

    localparam int CLK_PERIOD = 10;
    localparam int NPIN       = 4;
    localparam int WD_CYCLES  = 100000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic            irq_pending = 1'b0;
    logic            wake_evt = 1'b0;
    logic [NPIN-1:0] pullup_en = '0;
    logic [1:0]      pwr_mode;
    logic            cpu_clk_en, per_clk_en;
    logic [NPIN-1:0] pin_hiz, pin_pullup;
    logic            swrst_pulse, tmr_sel;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stby_ctrl_top #(.NPIN(NPIN)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .irq_pending(irq_pending), .wake_evt(wake_evt), .pullup_en(pullup_en),
        .pwr_mode(pwr_mode), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .pin_hiz(pin_hiz), .pin_pullup(pin_pullup),
        .swrst_pulse(swrst_pulse), .tmr_sel(tmr_sel)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Compares every output with a model value derived from the requirements.
    task automatic chk_all(input string tag, input logic [1:0] m, input logic spl,
                           input logic tm, input logic sr);
        logic [NPIN-1:0] hz;
        hz = (m == 2'b10 && spl) ? '1 : '0;
        chk({tag, " R3 R4 R5 mode"}, {6'b0, pwr_mode}, {6'b0, m});
        chk({tag, " R3 R4 cpu_clk_en"}, {7'b0, cpu_clk_en}, {7'b0, m == 2'b00});
        chk({tag, " R3 R4 per_clk_en"}, {7'b0, per_clk_en}, {7'b0, m != 2'b10});
        chk({tag, " R2 rdata"}, rdata, {2'b00, spl, 5'b0});
        chk({tag, " R8 pin_hiz"}, {4'b0, pin_hiz}, {4'b0, hz});
        chk({tag, " R8 pin_pullup"}, {4'b0, pin_pullup}, {4'b0, hz & pullup_en});
        chk({tag, " R10 tmr_sel"}, {7'b0, tmr_sel}, {7'b0, tm});
        chk({tag, " R9 swrst_pulse"}, {7'b0, swrst_pulse}, {7'b0, sr});
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [1:0] em;
        logic       etm;
        repeat (3) @(negedge clk);
        chk_all("R1 reset", 2'b00, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 after release", 2'b00, 1'b0, 1'b0, 1'b0);

        for (int irq = 0; irq < 2; irq++) begin
            for (int vi = 0; vi < 256; vi++) begin
                logic [7:0] v;
                v = vi[7:0];
                pullup_en   = v[NPIN-1:0];
                irq_pending = irq[0];
                do_write(v);
                if (irq != 0)  em = 2'b00;          // R6
                else if (v[7]) em = 2'b10;          // R3 R5
                else if (v[6]) em = 2'b01;          // R4
                else           em = 2'b00;
                etm = v[3];
                chk_all("sweep write", em, v[5], etm, v[4]);
                irq_pending = 1'b0;
                @(negedge clk);
                chk_all("R9 R11 next cycle", em, v[5], etm, 1'b0);
                if (em != 2'b00 && v[2]) begin
                    do_write({2'b11, v[5], 5'b0});
                    etm = 1'b0;
                    chk_all("R11 request in low power", em, v[5], etm, 1'b0);
                end
                if (em != 2'b00) begin
                    @(negedge clk);
                    if (v[0]) wake_evt = 1'b1;
                    else      irq_pending = 1'b1;
                    @(negedge clk);
                    wake_evt    = 1'b0;
                    irq_pending = 1'b0;
                    chk_all("R7 exit", 2'b00, v[5], etm, 1'b0);
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule